// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block prepares the second operand of a 32-bit RISC datapath. It takes one operand word and applies one of four shift kinds by an amount. The amount comes either from a 5-bit immediate field or from the low bits of a register value. Next to the shifted word it returns the carry candidate that a flag-setting instruction would latch. An immediate amount of zero does not always mean "no shift". Its meaning depends on the shift kind, and each case has a defined carry.

A second mode builds a 32-bit constant from an 8-bit byte and a 4-bit rotate field. The byte is zero-extended and then rotated right by twice the field. The block has no clock, no reset and no state. Flag storage, the ALU and instruction decoding stay outside it. The block only delivers the value and the carry candidate to them.

Top module: `operand_shifter`

## Requirements
- R1: `kind_i` selects the shift kind: 0 shifts left logically, 1 shifts right logically, 2 shifts right arithmetically, 3 rotates right. An immediate amount from 1 to 31 shifts `opnd_i` by that many places.
- R2: An immediate amount of zero with kind 0 passes `opnd_i` through unchanged, and `carry_o` equals `carry_i`.
- R3: An immediate amount of zero with kind 1 acts as a logical right shift by 32: the result is zero and `carry_o` is `opnd_i[31]`.
- R4: An immediate amount of zero with kind 2 fills every result bit with `opnd_i[31]`, and `carry_o` is `opnd_i[31]`.
- R5: An immediate amount of zero with kind 3 rotates right by one place through the carry: the result is `{carry_i, opnd_i[31:1]}` and `carry_o` is `opnd_i[0]`.
- R6: With `amt_from_reg_i` high, only `amt_reg_i[4:0]` sets the count. The upper register bits and `amt_imm_i` have no effect.
- R7: A register count of zero passes `opnd_i` through with `carry_o` equal to `carry_i`, for every kind including 3.
- R8: For a nonzero count n, `carry_o` is `opnd_i[32-n]` for a left shift, `opnd_i[n-1]` for either right shift, and result bit 31 for a rotate.
- R9: With `const_mode_i` high, the result is `const_byte_i` zero-extended and rotated right by 2×`const_rot_i`.
- R10: In constant mode, `carry_o` is `carry_i` when `const_rot_i` is zero and result bit 31 otherwise. `opnd_i`, `kind_i` and the amount inputs have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand word to shift |
| kind_i | input | 2 | Shift kind (0 left, 1 right logical, 2 right arithmetic, 3 rotate) |
| amt_imm_i | input | 5 | Immediate shift amount |
| amt_from_reg_i | input | 1 | High: take the amount from `amt_reg_i` |
| amt_reg_i | input | 32 | Register value that supplies the amount |
| carry_i | input | 1 | Current carry flag |
| const_mode_i | input | 1 | High: output the expanded immediate constant |
| const_byte_i | input | 8 | Constant byte |
| const_rot_i | input | 4 | Constant rotate field (amount is twice this) |
| result_o | output | 32 | Shifted operand or expanded constant |
| carry_o | output | 1 | Carry candidate |

## Verification
The hardest cases to reach are the ones where a zero in an amount field means different things. An immediate zero behaves differently for each of the four kinds. A register zero always means pass-through, and a rotate by a register zero must not fall into the one-bit carry rotate. The stimulus reaches these cases with register values whose low five bits are zero but whose upper bits are not. It also sets a nonzero immediate field while the register path is selected. Finally, a sweep over all 32 register counts for every kind compares the result against a per-bit model. That sweep covers each carry-bit position at both ends of the range.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;
endpackage

// File: rtl/opsh_amt_decode.sv
// Resolves the effective shift count and the special zero-amount cases.
module opsh_amt_decode
  import opsh_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W),
  parameter int unsigned CW = SW + 1
) (
  input  sh_kind_e        kind_i,
  input  logic [SW-1:0]   imm_i,
  input  logic            from_reg_i,
  input  logic [W-1:0]    reg_val_i,
  output logic [CW-1:0]   cnt_o,
  output logic            pass_o,
  output logic            rrx_o
);
  logic [SW-1:0] reg_low;
  assign reg_low = reg_val_i[SW-1:0];

  always_comb begin
    cnt_o  = '0;
    pass_o = 1'b0;
    rrx_o  = 1'b0;
    if (from_reg_i) begin
      cnt_o  = CW'(reg_low);
      pass_o = (reg_low == '0);
    end else if (imm_i != '0) begin
      cnt_o = CW'(imm_i);
    end else begin
      unique case (kind_i)
        SH_LSL:         pass_o = 1'b1;
        SH_LSR, SH_ASR: cnt_o  = CW'(W);
        SH_ROR:         rrx_o  = 1'b1;
        default:        pass_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    p_cnt_range_r6: assert (cnt_o <= CW'(W));
    p_one_special_r5: assert (!(pass_o && rrx_o));
    p_reg_no_rrx_r7: assert (!(from_reg_i && rrx_o));
  end
endmodule

// File: rtl/opsh_shift_core.sv
// Computes all four shift kinds with their carry and selects one.
module opsh_shift_core
  import opsh_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  opnd_i,
  input  sh_kind_e      kind_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          pass_i,
  input  logic          rrx_i,
  input  logic          cin_i,
  output logic [W-1:0]  res_o,
  output logic          cout_o
);
  // Each helper returns {carry, result}.
  function automatic logic [W:0] f_left(input logic [W-1:0] op, input logic [CW-1:0] n);
    logic [2*W-1:0] wide;
    wide = {{W{1'b0}}, op} << n;
    return {wide[W], wide[W-1:0]};
  endfunction

  function automatic logic [W:0] f_right(input logic [W-1:0] op, input logic [CW-1:0] n,
                                         input logic arith);
    logic [2*W-1:0] wide;
    if (arith) wide = $signed({op, {W{1'b0}}}) >>> n;
    else       wide = {op, {W{1'b0}}} >> n;
    return {wide[W-1], wide[2*W-1:W]};
  endfunction

  function automatic logic [W:0] f_rot(input logic [W-1:0] op, input logic [CW-1:0] n);
    logic [W-1:0] r;
    r = (op >> n) | (op << (CW'(W) - n));
    return {r[W-1], r};
  endfunction

  logic [W:0] lsl_pair, lsr_pair, asr_pair, ror_pair, pick;

  assign lsl_pair = f_left(opnd_i, cnt_i);
  assign lsr_pair = f_right(opnd_i, cnt_i, 1'b0);
  assign asr_pair = f_right(opnd_i, cnt_i, 1'b1);
  assign ror_pair = f_rot(opnd_i, cnt_i);

  always_comb begin
    if (pass_i)     pick = {cin_i, opnd_i};
    else if (rrx_i) pick = {opnd_i[0], cin_i, opnd_i[W-1:1]};
    else begin
      unique case (kind_i)
        SH_LSL:  pick = lsl_pair;
        SH_LSR:  pick = lsr_pair;
        SH_ASR:  pick = asr_pair;
        default: pick = ror_pair;
      endcase
    end
  end

  assign {cout_o, res_o} = pick;

  always_comb begin
    if (!pass_i && !rrx_i && kind_i == SH_LSR && cnt_i == CW'(W))
      p_lsr_full_r3: assert (res_o == '0 && cout_o == opnd_i[W-1]);
    if (!pass_i && !rrx_i && kind_i == SH_ASR)
      p_asr_top_r8: assert (res_o[W-1] == opnd_i[W-1]);
  end
endmodule

// File: rtl/opsh_imm_expand.sv
// Expands a byte and rotate field into a word via log-stage rotation.
module opsh_imm_expand #(
  parameter int unsigned W  = 32,
  parameter int unsigned BW = 8,
  parameter int unsigned RW = 4
) (
  input  logic [BW-1:0] byte_i,
  input  logic [RW-1:0] rot_i,
  input  logic          cin_i,
  output logic [W-1:0]  val_o,
  output logic          cout_o
);
  logic [W-1:0] stg [RW+1];

  assign stg[0] = W'(byte_i);

  for (genvar k = 0; k < RW; k++) begin : g_stage
    localparam int unsigned SH = 2 ** (k + 1);
    assign stg[k+1] = rot_i[k] ? {stg[k][SH-1:0], stg[k][W-1:SH]} : stg[k];
  end

  assign val_o  = stg[RW];
  assign cout_o = (rot_i == '0) ? cin_i : val_o[W-1];

  always_comb begin
    p_popcnt_r9: assert ($countones(val_o) == $countones(byte_i));
    if (rot_i == '0)
      p_zero_rot_r10: assert (val_o == W'(byte_i) && cout_o == cin_i);
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opsh_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CBYTE_W = 8,
  parameter int unsigned CROT_W  = 4
) (
  input  logic [XLEN-1:0]          opnd_i,
  input  logic [1:0]               kind_i,
  input  logic [$clog2(XLEN)-1:0]  amt_imm_i,
  input  logic                     amt_from_reg_i,
  input  logic [XLEN-1:0]          amt_reg_i,
  input  logic                     carry_i,
  input  logic                     const_mode_i,
  input  logic [CBYTE_W-1:0]       const_byte_i,
  input  logic [CROT_W-1:0]        const_rot_i,
  output logic [XLEN-1:0]          result_o,
  output logic                     carry_o
);
  localparam int unsigned SW = $clog2(XLEN);
  localparam int unsigned CW = SW + 1;

  sh_kind_e       kind;
  logic [CW-1:0]  cnt;
  logic           pass_evt, rrx_evt;
  logic [XLEN-1:0] sh_res, k_res;
  logic           sh_c, k_c;

  assign kind = sh_kind_e'(kind_i);

  opsh_amt_decode #(.W(XLEN)) u_dec (
    .kind_i(kind), .imm_i(amt_imm_i), .from_reg_i(amt_from_reg_i),
    .reg_val_i(amt_reg_i), .cnt_o(cnt), .pass_o(pass_evt), .rrx_o(rrx_evt)
  );

  opsh_shift_core #(.W(XLEN)) u_core (
    .opnd_i(opnd_i), .kind_i(kind), .cnt_i(cnt), .pass_i(pass_evt),
    .rrx_i(rrx_evt), .cin_i(carry_i), .res_o(sh_res), .cout_o(sh_c)
  );

  opsh_imm_expand #(.W(XLEN), .BW(CBYTE_W), .RW(CROT_W)) u_kexp (
    .byte_i(const_byte_i), .rot_i(const_rot_i), .cin_i(carry_i),
    .val_o(k_res), .cout_o(k_c)
  );

  assign result_o = const_mode_i ? k_res : sh_res;
  assign carry_o  = const_mode_i ? k_c   : sh_c;

  logic imm_zero_sel;
  assign imm_zero_sel = !const_mode_i && !amt_from_reg_i && (amt_imm_i == '0);

  always_comb begin
    if (imm_zero_sel && kind == SH_LSL)
      p_pass_imm_r2: assert (result_o == opnd_i && carry_o == carry_i);
    if (imm_zero_sel && kind == SH_ASR)
      p_sign_fill_r4: assert (result_o == {XLEN{opnd_i[XLEN-1]}} && carry_o == opnd_i[XLEN-1]);
    if (imm_zero_sel && kind == SH_ROR)
      p_rrx_r5: assert (carry_o == opnd_i[0] && result_o[XLEN-1] == carry_i
                        && result_o[XLEN-2:0] == opnd_i[XLEN-1:1]);
    if (!const_mode_i && amt_from_reg_i && amt_reg_i[SW-1:0] == '0)
      p_pass_reg_r7: assert (result_o == opnd_i && carry_o == carry_i);
    if (!const_mode_i && !pass_evt && !rrx_evt && kind == SH_ROR)
      p_rot_carry_r8: assert (carry_o == result_o[XLEN-1]);
  end
endmodule

// File: tb/test_operand_shifter.sv
module test_operand_shifter;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] opnd = '0;
  logic [1:0]  kind = '0;
  logic [4:0]  aimm = '0;
  logic        afr  = 1'b0;
  logic [31:0] areg = '0;
  logic        cin  = 1'b0;
  logic        cmode = 1'b0;
  logic [7:0]  cbyte = '0;
  logic [3:0]  crot  = '0;
  logic [31:0] res;
  logic        cout;

  int checks = 0;
  int errors = 0;

  operand_shifter i_operand_shifter (
    .opnd_i(opnd), .kind_i(kind), .amt_imm_i(aimm), .amt_from_reg_i(afr),
    .amt_reg_i(areg), .carry_i(cin), .const_mode_i(cmode),
    .const_byte_i(cbyte), .const_rot_i(crot), .result_o(res), .carry_o(cout)
  );

  typedef struct packed {
    logic [31:0] op;
    logic [1:0]  k;
    logic [4:0]  imm;
    logic        fr;
    logic [31:0] rg;
    logic        ci;
    logic [31:0] er;
    logic        ec;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'hF0000001, 2'd0, 5'd4, 1'b0, 32'h0,   1'b0, 32'h00000010, 1'b1}, // R1 left 4
    '{32'h12345680, 2'd1, 5'd8, 1'b0, 32'h0,   1'b0, 32'h00123456, 1'b1}, // R1 right logical 8
    '{32'h80000018, 2'd2, 5'd4, 1'b0, 32'h0,   1'b0, 32'hF8000001, 1'b1}, // R1 right arith 4
    '{32'h123456AB, 2'd3, 5'd8, 1'b0, 32'h0,   1'b0, 32'hAB123456, 1'b1}, // R1 rotate 8
    '{32'h80000000, 2'd0, 5'd1, 1'b0, 32'h0,   1'b0, 32'h00000000, 1'b1}, // R8 left 1 carry bit31
    '{32'hDEADBEEF, 2'd0, 5'd0, 1'b0, 32'h0,   1'b1, 32'hDEADBEEF, 1'b1}, // R2
    '{32'h80000000, 2'd1, 5'd0, 1'b0, 32'h0,   1'b0, 32'h00000000, 1'b1}, // R3
    '{32'h7FFFFFFF, 2'd1, 5'd0, 1'b0, 32'h0,   1'b1, 32'h00000000, 1'b0}, // R3
    '{32'h80000000, 2'd2, 5'd0, 1'b0, 32'h0,   1'b0, 32'hFFFFFFFF, 1'b1}, // R4
    '{32'h7FFFFFFF, 2'd2, 5'd0, 1'b0, 32'h0,   1'b1, 32'h00000000, 1'b0}, // R4
    '{32'h00000003, 2'd3, 5'd0, 1'b0, 32'h0,   1'b1, 32'h80000001, 1'b1}, // R5
    '{32'h00000002, 2'd3, 5'd0, 1'b0, 32'h0,   1'b0, 32'h00000001, 1'b0}, // R5
    '{32'h000000F4, 2'd1, 5'd9, 1'b1, 32'h23,  1'b0, 32'h0000001E, 1'b1}, // R6 low bits 3
    '{32'h00000055, 2'd0, 5'd7, 1'b1, 32'h120, 1'b0, 32'h00000055, 1'b0}, // R7 / R6 upper ignored
    '{32'h00000055, 2'd3, 5'd0, 1'b1, 32'h0,   1'b1, 32'h00000055, 1'b1}, // R7 rotate no carry-rotate
    '{32'h00008001, 2'd3, 5'd0, 1'b1, 32'h10,  1'b0, 32'h80010000, 1'b1}  // R8 rotate carry
  };

  task automatic check(input string tag, input logic [31:0] er, input logic ec);
    checks++;
    if (res !== er || cout !== ec) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b expected res=%h c=%b", tag, res, cout, er, ec);
    end
  endtask

  task automatic drive_shift(input logic [31:0] op, input logic [1:0] k, input logic [4:0] im,
                             input logic fr, input logic [31:0] rg, input logic ci);
    @(posedge clk);
    cmode = 1'b0; opnd = op; kind = k; aimm = im; afr = fr; areg = rg; cin = ci;
    #5;
  endtask

  task automatic drive_const(input logic [7:0] b, input logic [3:0] r, input logic ci,
                             input logic [31:0] op, input logic [1:0] k);
    @(posedge clk);
    cmode = 1'b1; cbyte = b; crot = r; cin = ci; opnd = op; kind = k;
    aimm = 5'd13; afr = 1'b1; areg = 32'h7;
    #5;
  endtask

  // Per-bit model for a register count 0..31, {carry, result}.
  function automatic logic [32:0] model(input logic [31:0] op, input logic [1:0] k,
                                        input int n, input logic ci);
    logic [31:0] r;
    logic c;
    if (n == 0) return {ci, op};
    for (int i = 0; i < 32; i++) begin
      case (k)
        2'd0: r[i] = (i >= n) ? op[i-n] : 1'b0;
        2'd1: r[i] = (i + n < 32) ? op[i+n] : 1'b0;
        2'd2: r[i] = (i + n < 32) ? op[i+n] : op[31];
        default: r[i] = op[(i+n)%32];
      endcase
    end
    if (k == 2'd0)      c = op[32-n];
    else if (k == 2'd3) c = r[31];
    else                c = op[n-1];
    return {c, r};
  endfunction

  initial begin
    logic [32:0] exp_pair;
    #5;
    check("R1 idle inputs give zero", 32'h0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      drive_shift(VECS[v].op, VECS[v].k, VECS[v].imm, VECS[v].fr, VECS[v].rg, VECS[v].ci);
      check($sformatf("table row %0d", v), VECS[v].er, VECS[v].ec);
    end

    // R8 and R6: every register count, every kind, with noisy upper bits.
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 32; n++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] op;
          logic ci;
          op = (p == 0) ? 32'hA5C3_0F96 : 32'h5A3C_F069;
          ci = (p == 1);
          drive_shift(op, 2'(k), 5'(31 - n), 1'b1, {27'h5A5A5A5, 5'(n)}, ci);
          exp_pair = model(op, 2'(k), n, ci);
          check($sformatf("R8 sweep kind %0d n %0d", k, n), exp_pair[31:0], exp_pair[32]);
        end
      end
    end

    // R1 immediate sweep for rotate against the model.
    for (int n = 1; n < 32; n++) begin
      drive_shift(32'h8421_1248, 2'd3, 5'(n), 1'b0, 32'hFFFF_FFFF, 1'b0);
      exp_pair = model(32'h8421_1248, 2'd3, n, 1'b0);
      check($sformatf("R1 imm rotate %0d", n), exp_pair[31:0], exp_pair[32]);
    end

    // R9 / R10 constant mode
    drive_const(8'hFF, 4'd0, 1'b1, 32'h1234_5678, 2'd1);
    check("R10 rotate zero keeps carry", 32'h0000_00FF, 1'b1);
    drive_const(8'hFF, 4'd0, 1'b0, 32'h1234_5678, 2'd2);
    check("R10 rotate zero keeps carry low", 32'h0000_00FF, 1'b0);
    drive_const(8'hFF, 4'd4, 1'b0, 32'h0, 2'd0);
    check("R9 rotate by 8", 32'hFF00_0000, 1'b1);
    drive_const(8'h3F, 4'd15, 1'b1, 32'h0, 2'd0);
    check("R9 rotate by 30", 32'h0000_00FC, 1'b0);
    drive_const(8'h01, 4'd1, 1'b1, 32'h0, 2'd0);
    check("R9 rotate by 2", 32'h4000_0000, 1'b0);
    drive_const(8'h02, 4'd1, 1'b0, 32'h0, 2'd3);
    check("R10 carry from bit 31", 32'h8000_0000, 1'b1);
    drive_const(8'h02, 4'd1, 1'b0, 32'hFFFF_FFFF, 2'd1);
    check("R10 operand ignored", 32'h8000_0000, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule